// File: doc/BRIEF.md
# Serial Panel Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of a small display panel controller over a four-wire serial link. A single host request becomes two 24-bit serial frames. The first frame always selects the register. The second either carries the value to store or clocks back the register contents.

Every frame starts with an 8-bit header: a 6-bit device identifier (default 0x1D) in the upper six bits and a 2-bit mode code in the lower two. The header is followed by a 16-bit payload. The host raises `start_i` for one cycle with the direction, register number and write value. When the access has finished, the block pulses `done_o`. For reads, `rdata_o` then holds the returned word. A parameter sets the serial clock half-period in system clock cycles.

Top module: `spi_panel_regmaster`

## Requirements
- R1: While reset is asserted and whenever no access is in progress, `ss_n_o`, `sclk_o` and `mosi_o` are high and `done_o` is low; `rdata_o` resets to 0.
- R2: The first frame of every access is header 0x74 (device 0x1D, mode 0 = index write), then a zero byte, then the 8-bit register number, giving the word {0x74, 0x00, idx}.
- R3: For a write, the second frame is header 0x76 (mode 2 = data write) followed by the 16-bit write value.
- R4: For a read, the second frame is header 0x77 (mode 3 = data read) followed by 16 zero bits. `rdata_o` becomes the last 16 bits sampled from `miso_i` during that frame, taken MSB first, with each bit sampled at the system clock edge where `sclk_o` rises.
- R5: Bits leave MSB first. For each bit, `sclk_o` is low for HALF_DIV cycles and then high for HALF_DIV cycles. `mosi_o` changes only together with a falling `sclk_o` (or when the frame ends) and holds steady while `sclk_o` is high.
- R6: `ss_n_o` is low for each frame alone. It falls HALF_DIV cycles before the first falling `sclk_o`, rises HALF_DIV cycles after the last rising `sclk_o`, and stays high for HALF_DIV cycles between the two frames. `sclk_o` is never low while `ss_n_o` is high.
- R7: `start_i` is ignored while an access is in progress. A request held high is taken at the first edge after the block has returned to idle, which is the edge after the `done_o` cycle.
- R8: `done_o` is high for exactly one cycle, one clock after `ss_n_o` rises at the end of the second frame. `rdata_o` changes only in that cycle, and only for reads.
- R9: An access taken at clock edge E ends with `done_o` high after edge E + 99*HALF_DIV + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| idx_i | input | 8 | Register number |
| wdata_i | input | 16 | Value to write |
| rdata_o | output | 16 | Value returned by the last read |
| done_o | output | 1 | One-cycle completion pulse |
| ss_n_o | output | 1 | Panel select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the panel, idles high |
| miso_i | input | 1 | Serial data from the panel |

## Verification
The tests use writes and reads whose register numbers and values have differing bit patterns: all ones, all zeros, a single set bit at each end, and mixed words. These separate a bit-order or header mistake from a shift-count mistake. While the sampling edge is not near, the panel model drives a changing value that does not match the wanted bit, so sampling one cycle early or late gives a wrong read word. A write placed between two reads shows that writes leave the read result untouched. A request held high across a whole access tests that the block ignores it while busy and takes it at the first legal edge. The divider runs at a value other than its default, which tests every half-period length and the total access length.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int HDR_W   = 8;
  localparam int PAY_W   = 16;
  localparam int FRAME_W = HDR_W + PAY_W;

  typedef enum logic [1:0] {
    MODE_IDX_WR  = 2'd0,
    MODE_STAT_RD = 2'd1,
    MODE_DAT_WR  = 2'd2,
    MODE_DAT_RD  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH,
    PH_GAP,
    PH_FIN
  } phase_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [5:0]       dev,
    input mode_e            mode,
    input logic [PAY_W-1:0] pay
  );
    return {dev, mode, pay};
  endfunction
endpackage

// File: rtl/spm_halfclk.sv
module spm_halfclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int DIV   = (HALF_DIV < 1) ? 1 : HALF_DIV;
  localparam int CNT_W = $clog2(DIV + 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spm_shifter.sv
module spm_shifter
  import spm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               fall_i,
  input  logic               rise_i,
  input  logic               release_i,
  input  logic               miso_i,
  output logic               mosi_o,
  output logic [PAY_W-1:0]   rx_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
    end else if (rise_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosi_q <= 1'b1;
    end else if (fall_i) begin
      mosi_q <= sr_q[FRAME_W-1];
    end else if (release_i) begin
      mosi_q <= 1'b1;
    end
  end

  assign mosi_o = mosi_q;
  assign rx_o   = sr_q[PAY_W-1:0];
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'h1D,
  parameter int         IDX_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [PAY_W-1:0]   wdata_i,
  input  logic               tick_i,
  input  logic [PAY_W-1:0]   rx_i,
  output logic               run_o,
  output logic               load_o,
  output logic [FRAME_W-1:0] word_o,
  output logic               fall_o,
  output logic               rise_o,
  output logic               release_o,
  output logic               accept_o,
  output logic               ss_n_o,
  output logic               sclk_o,
  output logic               done_o,
  output logic [PAY_W-1:0]   rdata_o
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  phase_e            ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic              second_q;
  logic              rd_q;
  logic [PAY_W-1:0]  wdata_q;
  logic              ss_n_q;
  logic              sclk_q;
  logic              done_q;
  logic [PAY_W-1:0]  rdata_q;

  logic              last_bit;
  logic              gap_end;
  logic [FRAME_W-1:0] first_word;
  logic [FRAME_W-1:0] second_word;

  assign last_bit  = (bit_q == LAST_BIT);
  assign accept_o  = (ph_q == PH_IDLE) && start_i;
  assign gap_end   = (ph_q == PH_GAP) && tick_i;
  assign fall_o    = ((ph_q == PH_SETUP) && tick_i) ||
                     ((ph_q == PH_HIGH) && tick_i && !last_bit);
  assign rise_o    = (ph_q == PH_LOW) && tick_i;
  assign release_o = (ph_q == PH_HIGH) && tick_i && last_bit;
  assign load_o    = accept_o || gap_end;
  assign run_o     = (ph_q != PH_IDLE);

  assign first_word  = build_frame(DEV_ID, MODE_IDX_WR, PAY_W'(idx_i));
  assign second_word = rd_q ? build_frame(DEV_ID, MODE_DAT_RD, '0)
                            : build_frame(DEV_ID, MODE_DAT_WR, wdata_q);
  assign word_o      = accept_o ? first_word : second_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      bit_q    <= '0;
      second_q <= 1'b0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
      ss_n_q   <= 1'b1;
      sclk_q   <= 1'b1;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            rd_q     <= rd_i;
            wdata_q  <= wdata_i;
            second_q <= 1'b0;
            ss_n_q   <= 1'b0;
            ph_q     <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (tick_i) begin
            sclk_q <= 1'b0;
            bit_q  <= '0;
            ph_q   <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (tick_i) begin
            sclk_q <= 1'b1;
            ph_q   <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick_i) begin
            if (last_bit) begin
              ss_n_q <= 1'b1;
              ph_q   <= second_q ? PH_FIN : PH_GAP;
            end else begin
              bit_q  <= bit_q + 1'b1;
              sclk_q <= 1'b0;
              ph_q   <= PH_LOW;
            end
          end
        end
        PH_GAP: begin
          if (tick_i) begin
            second_q <= 1'b1;
            ss_n_q   <= 1'b0;
            ph_q     <= PH_SETUP;
          end
        end
        PH_FIN: begin
          done_q <= 1'b1;
          if (rd_q) begin
            rdata_q <= rx_i;
          end
          ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ss_n_o  = ss_n_q;
  assign sclk_o  = sclk_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/spi_panel_regmaster.sv
module spi_panel_regmaster
  import spm_pkg::*;
#(
  parameter int         HALF_DIV = 2,
  parameter logic [5:0] DEV_ID   = 6'h1D,
  parameter int         IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output logic             done_o,
  output logic             ss_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic               half_tick;
  logic               ctl_run;
  logic               sh_load;
  logic [FRAME_W-1:0] sh_word;
  logic               sh_fall;
  logic               sh_rise;
  logic               sh_release;
  logic [PAY_W-1:0]   sh_rx;
  logic               acc_take;

  spm_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (ctl_run),
    .tick_o (half_tick)
  );

  spm_ctrl #(.DEV_ID(DEV_ID), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_i      (rd_i),
    .idx_i     (idx_i),
    .wdata_i   (wdata_i),
    .tick_i    (half_tick),
    .rx_i      (sh_rx),
    .run_o     (ctl_run),
    .load_o    (sh_load),
    .word_o    (sh_word),
    .fall_o    (sh_fall),
    .rise_o    (sh_rise),
    .release_o (sh_release),
    .accept_o  (acc_take),
    .ss_n_o    (ss_n_o),
    .sclk_o    (sclk_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o)
  );

  spm_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (sh_load),
    .word_i    (sh_word),
    .fall_i    (sh_fall),
    .rise_i    (sh_rise),
    .release_i (sh_release),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_o      (sh_rx)
  );
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ss_n_o,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        acc_take
);
  AST_SCLK_LOW_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> !ss_n_o); // R6

  AST_MOSI_STEADY_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && !ss_n_o && !$past(ss_n_o)) |-> $stable(mosi_o)); // R5

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_SELECT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ss_n_o && $past(ss_n_o) && !$past(ss_n_o, 2))); // R8

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o)); // R8

  AST_TAKE_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take |-> (ss_n_o && sclk_o && mosi_o)); // R7
endmodule

bind spi_panel_regmaster spm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ss_n_o   (ss_n_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .done_o   (done_o),
  .rdata_o  (rdata_o),
  .acc_take (acc_take)
);

// File: tb/spi_panel_regmaster_test.sv
`timescale 1ns/1ps
module spi_panel_regmaster_test;
  localparam int H = 3;
  localparam int DONE_N = 99 * H + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  idx_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        done_o;
  logic        ss_n_o;
  logic        sclk_o;
  logic        mosi_o;
  logic        miso_i = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi_panel_regmaster #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .idx_i(idx_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .ss_n_o(ss_n_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  // reference model state
  int          cyc = 0;
  int          e0 = 0;
  bit          m_active = 0;
  bit          m_rd = 0;
  logic [23:0] w0, w1;
  logic [23:0] slave_word = 24'h0;
  logic [23:0] m_resp = 24'h0;
  logic [15:0] exp_rdata = 16'h0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_active = 0;
      exp_rdata = 16'h0;
    end else begin
      if (m_active && (cyc - e0) == DONE_N && m_rd) exp_rdata = m_resp[15:0];
      if (start_i && (!m_active || (cyc - e0) >= DONE_N + 1)) begin
        m_active = 1;
        e0 = cyc;
        m_rd = rd_i;
        m_resp = slave_word;
        w0 = {8'h74, 8'h00, idx_i};
        w1 = rd_i ? {8'h77, 16'h0000} : {8'h76, wdata_i};
      end
    end
  end

  // per-cycle comparison and panel-side data driver
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_ss, e_sclk, e_mosi, e_done;
      string mreq;
      int n, q, k, ph, nn;
      e_ss = 1; e_sclk = 1; e_mosi = 1; e_done = 0; mreq = "R1";
      if (m_active) begin
        n = cyc - e0;
        if (n < 49 * H) begin
          q = n; mreq = "R2";
          e_ss = 0;
          if (q >= H) begin
            k = (q - H) / (2 * H); ph = (q - H) % (2 * H);
            e_sclk = (ph >= H); e_mosi = w0[23 - k];
          end
        end else if (n >= 50 * H && n < 99 * H) begin
          q = n - 50 * H; mreq = m_rd ? "R4" : "R3";
          e_ss = 0;
          if (q >= H) begin
            k = (q - H) / (2 * H); ph = (q - H) % (2 * H);
            e_sclk = (ph >= H); e_mosi = w1[23 - k];
          end
        end
        e_done = (n == DONE_N);
      end
      chk("R6 select", {31'b0, ss_n_o}, {31'b0, e_ss});
      chk("R5 sclk", {31'b0, sclk_o}, {31'b0, e_sclk});
      chk({mreq, " R5 mosi"}, {31'b0, mosi_o}, {31'b0, e_mosi});
      chk("R8 R9 done", {31'b0, done_o}, {31'b0, e_done});
      chk("R8 rdata", {16'b0, rdata_o}, {16'b0, exp_rdata});
      // drive the bit for the next edge; off the sampling edge, drive a wrong value
      miso_i = cyc[0];
      if (m_active) begin
        nn = cyc + 1 - e0 - 50 * H;
        if (nn >= 2 * H && (nn - 2 * H) % (2 * H) == 0 && (nn - 2 * H) / (2 * H) < 24)
          miso_i = m_resp[23 - (nn - 2 * H) / (2 * H)];
        else if (nn >= 0 && nn < 49 * H)
          miso_i = ~m_resp[23 - ((nn >= H) ? ((nn - H) / (2 * H)) : 0)];
      end
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) return;
    end
  endtask

  task automatic access(input bit rd, input logic [7:0] idx, input logic [15:0] wd,
                        input logic [23:0] resp);
    @(negedge clk);
    slave_word = resp;
    rd_i = rd; idx_i = idx; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset select", {31'b0, ss_n_o}, 32'd1);
    chk("R1 reset sclk", {31'b0, sclk_o}, 32'd1);
    chk("R1 reset mosi", {31'b0, mosi_o}, 32'd1);
    chk("R1 reset done", {31'b0, done_o}, 32'd0);
    chk("R1 reset rdata", {16'b0, rdata_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    access(1'b0, 8'h07, 16'h0015, 24'h0);                 // R3 mixed word
    access(1'b1, 8'h00, 16'hDEAD, 24'hA50139);            // R4 read
    chk("R4 read word", {16'b0, rdata_o}, 32'h0139);
    access(1'b0, 8'hFF, 16'hFFFF, 24'h0);                 // R2 R3 all ones
    chk("R8 write keeps rdata", {16'b0, rdata_o}, 32'h0139);
    access(1'b1, 8'h80, 16'h0000, 24'h5A8001);            // R4 end bits
    chk("R4 read end bits", {16'b0, rdata_o}, 32'h8001);
    access(1'b0, 8'h01, 16'h8001, 24'h0);                 // R3 single bits
    access(1'b1, 8'h22, 16'h1234, 24'hFFFFFF);            // R4 all ones
    chk("R4 read all ones", {16'b0, rdata_o}, 32'hFFFF);
    access(1'b1, 8'h41, 16'h0, 24'h000000);               // R4 all zeros
    chk("R4 read all zeros", {16'b0, rdata_o}, 32'h0000);

    // R7: hold the request across a busy access, change fields mid-access
    @(negedge clk);
    slave_word = 24'h00C3A5;
    rd_i = 1'b0; idx_i = 8'h10; wdata_i = 16'h1A20; start_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b1; idx_i = 8'h33;
    wait_done();
    chk("R7 busy request ignored", {31'b0, ss_n_o}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 held request taken", {31'b0, ss_n_o}, 32'd0);
    wait_done();
    chk("R7 R4 held read word", {16'b0, rdata_o}, 32'hC3A5);
    repeat (10) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual cycle %0d, expected finish earlier", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule